// File: doc/BRIEF.md
# Layer Scanout Address Generator

This block walks a single full-screen XRGB8888 layer in memory while the display refreshes and issues one fetch request per 32-bit pixel. Every address it issues is a 36-bit bit address, so the low five bits of each request are always zero. Software programs the base, line stride, layer size, display size, pixel format and mode through a small write port. The timing logic supplies a frame-start strobe, the parity of the field that follows, and a line-advance strobe.

All writes land in a shadow set. A commit write arms a transfer, and the shadow set becomes active at the next frame start. The frame then begins one cycle later from the active set. In interlaced mode each field fetches every other line of the frame. The odd field starts one stride below the base.

Top module: `layer_scan_addr`

## Requirements
- R1: After reset no request is raised, and none is raised after a frame start until a configuration has been committed.
- R2: Writes to select 0 (mode), 1 (display size), 2 (layer size), 3 (stride, bits), 4 (base bits 31:0), 5 (base bits 35:32 in data 3:0) and 6 (format) change nothing until they are committed.
- R3: A write of 1 in data bit 0 to select 7 arms a transfer. The transfer copies the shadow set to the active set at the next frame start, and then disarms itself, so later uncommitted writes are not applied at a later frame start.
- R4: Two cycles after the cycle in which frame start is sampled, the first request of the frame carries the 36-bit bit address formed from the base high nibble above the base low word. Its bits 4:0 are zero.
- R5: Within a line, each accepted request is followed by one at the address 32 higher. A line holds min(layer width, display width) requests, and each size register holds height-1 in bits 31:16 and width-1 in bits 15:0. After the last request of a line, the valid output stays low until the next line advance.
- R6: In progressive mode a line advance moves the line start by the stride and restarts at the first word of the line.
- R7: A frame has min(layer height, display height) lines. The line advance that follows the last line ends the frame, and no request is raised until the next frame start.
- R8: With mode bit 28 set, a field has half the programmed height in lines, and a line advance moves the line start by twice the stride. The even field starts at the base, and the odd field (field_odd high with frame start) starts one stride past the base.
- R9: Fetching starts only when mode bits 0, 1 and 8 are all set, the format field in bits 11:8 equals 9, and format bits 3:0 equal 0. Otherwise the frame raises no request.
- R10: While valid is high and ready is low, valid stays high and the address does not change.
- R11: A frame start stops the current frame at once, and wins over a line advance in the same cycle. The next frame restarts at line 0.
- R12: A commit write in the same cycle as a frame start is not applied at that frame start. It is applied at the following one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Start of frame or field |
| field_odd | input | 1 | Field parity, sampled with frame_start |
| line_adv | input | 1 | Advance to the next line |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Fetch request accepted |
| req_addr | output | 36 | Fetch bit address |

## Verification
A frame start and a line advance can arrive in the same cycle. A commit write can also coincide with a frame start. The bench drives both strobes together in the middle of a frame. It expects valid to drop in the next cycle and the following request to sit at the base, which shows the restart won. It also issues a commit in the frame-start cycle after changing the shadow base. It expects the old base for that frame and the new base only after a second frame start.

// File: rtl/layer_scan_addr.sv
module layer_scan_addr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        frame_start,
  input  logic        field_odd,
  input  logic        line_adv,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [35:0] req_addr
);
  localparam logic [3:0] FMT_XRGB = 4'd9;

  logic [31:0] sh_mode, sh_dis, sh_lay, sh_stride, sh_blo, sh_fmt;
  logic [3:0]  sh_bhi;
  logic [31:0] ac_mode, ac_dis, ac_lay, ac_stride, ac_blo, ac_fmt;
  logic [3:0]  ac_bhi;
  logic        pend, fs_d, odd_q;
  logic        busy, ldone;
  logic [15:0] x;
  logic [16:0] line;
  logic [35:0] ptr;

  wire        commit_wr = cfg_we && cfg_sel == 3'd7 && cfg_wdata[0];
  wire        ilace     = ac_mode[28];
  wire        run_ok    = ac_mode[0] && ac_mode[1] && ac_mode[8] &&
                          ac_fmt[11:8] == FMT_XRGB && ac_fmt[3:0] == 4'd0;
  wire [15:0] wl = (ac_lay[15:0]  < ac_dis[15:0])  ? ac_lay[15:0]  : ac_dis[15:0];
  wire [15:0] hl = (ac_lay[31:16] < ac_dis[31:16]) ? ac_lay[31:16] : ac_dis[31:16];
  wire [16:0] hcnt   = {1'b0, hl} + 17'd1;
  wire [16:0] nlines = ilace ? (hcnt >> 1) : hcnt;
  wire [35:0] base   = {ac_bhi, ac_blo};
  wire [35:0] strd   = {4'd0, ac_stride};
  wire [35:0] step   = ilace ? (strd << 1) : strd;
  wire [35:0] first  = base + ((ilace && odd_q) ? strd : 36'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_mode <= '0; sh_dis <= '0; sh_lay <= '0; sh_stride <= '0;
      sh_blo <= '0; sh_bhi <= '0; sh_fmt <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: sh_mode   <= cfg_wdata;
        3'd1: sh_dis    <= cfg_wdata;
        3'd2: sh_lay    <= cfg_wdata;
        3'd3: sh_stride <= cfg_wdata;
        3'd4: sh_blo    <= cfg_wdata;
        3'd5: sh_bhi    <= cfg_wdata[3:0];
        3'd6: sh_fmt    <= cfg_wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ac_mode <= '0; ac_dis <= '0; ac_lay <= '0; ac_stride <= '0;
      ac_blo <= '0; ac_bhi <= '0; ac_fmt <= '0;
      pend <= 1'b0; odd_q <= 1'b0;
    end else begin
      if (frame_start && pend) begin
        ac_mode <= sh_mode; ac_dis <= sh_dis; ac_lay <= sh_lay;
        ac_stride <= sh_stride; ac_blo <= sh_blo; ac_bhi <= sh_bhi;
        ac_fmt <= sh_fmt;
      end
      if (frame_start) odd_q <= field_odd;
      if (commit_wr) pend <= 1'b1;
      else if (frame_start) pend <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_d <= 1'b0; busy <= 1'b0; ldone <= 1'b0;
      x <= '0; line <= '0; ptr <= '0;
    end else begin
      fs_d <= frame_start;
      if (frame_start) begin
        busy <= 1'b0;
      end else if (fs_d) begin
        busy  <= run_ok && nlines != 17'd0;
        ptr   <= first;
        x     <= '0;
        line  <= '0;
        ldone <= 1'b0;
      end else if (busy && line_adv) begin
        if (line == nlines - 17'd1) busy <= 1'b0;
        line  <= line + 17'd1;
        ptr   <= ptr + step;
        x     <= '0;
        ldone <= 1'b0;
      end else if (req_valid && req_ready) begin
        if (x == wl) ldone <= 1'b1;
        else         x <= x + 16'd1;
      end
    end

  assign req_valid = busy && !ldone;
  assign req_addr  = {ptr[35:5] + {15'd0, x}, 5'd0};

  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !frame_start && !line_adv) |=> (req_valid && $stable(req_addr)));

  a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !frame_start && !line_adv) |=> (!req_valid || req_addr == $past(req_addr) + 36'd32));

  a_r4_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_d && !frame_start) |=> (!req_valid || req_addr == (first & ~36'h1F)));

  a_r11_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> ($past(fs_d) || $past(line_adv)));

  a_r11_stop: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !req_valid);
endmodule

// File: tb/layer_scan_addr_tb_top.sv
module layer_scan_addr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MODE_RUN = 32'h0000_0103;
  localparam logic [31:0] ILACE    = 32'h1000_0000;
  localparam logic [31:0] FMT_OK   = 32'h0000_0900;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frame_start = 1'b0, field_odd = 1'b0, line_adv = 1'b0, req_ready = 1'b0;
  logic        req_valid;
  logic [35:0] req_addr;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  layer_scan_addr dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .field_odd(field_odd), .line_adv(line_adv),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr));

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fs(input logic odd);
    frame_start = 1'b1; field_odd = odd;
    @(negedge clk);
    frame_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic adv();
    line_adv = 1'b1;
    @(negedge clk);
    line_adv = 1'b0;
  endtask

  task automatic take(input string req, input logic [35:0] exp);
    check(req, {35'd0, req_valid}, 36'd1);
    check(req, req_addr, exp);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  function automatic logic [35:0] baddr(input logic [32:0] byte_a);
    return {3'd0, byte_a} << 3;
  endfunction

  task automatic setup(input logic [32:0] byte_a, input int lw, input int lh,
                       input int dw, input int dh, input logic [31:0] stride,
                       input logic [31:0] mode, input logic [31:0] fmt, input bit commit);
    logic [35:0] b;
    b = baddr(byte_a);
    wr(3'd0, mode);
    wr(3'd1, {16'(dh - 1), 16'(dw - 1)});
    wr(3'd2, {16'(lh - 1), 16'(lw - 1)});
    wr(3'd3, stride);
    wr(3'd4, b[31:0]);
    wr(3'd5, {28'd0, b[35:32]});
    wr(3'd6, fmt);
    if (commit) wr(3'd7, 32'd1);
  endtask

  localparam logic [32:0] BASE_A = 33'h1_2345_6700;
  localparam logic [32:0] BASE_B = 33'h0_0040_0000;
  localparam logic [31:0] STR    = 32'd4096;

  task automatic t_reset();
    check("R1 reset valid", {35'd0, req_valid}, 36'd0);
    fs(1'b0);
    check("R1 no config", {35'd0, req_valid}, 36'd0);
  endtask

  task automatic t_shadow();
    setup(BASE_A, 4, 3, 6, 2, STR, MODE_RUN, FMT_OK, 1'b0);
    fs(1'b0);
    check("R2 uncommitted", {35'd0, req_valid}, 36'd0);
  endtask

  task automatic t_frame();
    logic [35:0] b;
    b = baddr(BASE_A);
    wr(3'd7, 32'd1);
    fs(1'b0);
    for (int i = 0; i < 4; i++) take("R4 R5 line0 word", b + 36'(32 * i));
    check("R5 line end", {35'd0, req_valid}, 36'd0);
    adv();
    take("R6 line1 start", b + 36'(STR));
    adv();
    check("R7 frame end", {35'd0, req_valid}, 36'd0);
  endtask

  task automatic t_noreload();
    wr(3'd4, baddr(BASE_B)[31:0]);
    wr(3'd5, {28'd0, baddr(BASE_B)[35:32]});
    fs(1'b0);
    check("R3 disarmed", req_addr, baddr(BASE_A));
  endtask

  task automatic t_commit_collide();
    cfg_we = 1'b1; cfg_sel = 3'd7; cfg_wdata = 32'd1; frame_start = 1'b1; field_odd = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; frame_start = 1'b0;
    @(negedge clk);
    check("R12 same-cycle commit", req_addr, baddr(BASE_A));
    fs(1'b0);
    check("R12 applied next", req_addr, baddr(BASE_B));
  endtask

  task automatic t_stall();
    logic [35:0] a;
    a = req_addr;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 stall valid", {35'd0, req_valid}, 36'd1);
      check("R10 stall addr", req_addr, a);
    end
  endtask

  task automatic t_fs_vs_adv();
    logic [35:0] b;
    b = baddr(BASE_B);
    take("R11 pre", b);
    adv();
    check("R11 mid line1", req_addr, b + 36'(STR));
    frame_start = 1'b1; line_adv = 1'b1; field_odd = 1'b0;
    @(negedge clk);
    frame_start = 1'b0; line_adv = 1'b0;
    check("R11 stopped", {35'd0, req_valid}, 36'd0);
    @(negedge clk);
    take("R11 restart", b);
  endtask

  task automatic t_ilace();
    logic [35:0] b;
    b = baddr(BASE_A);
    setup(BASE_A, 2, 4, 2, 4, STR, MODE_RUN | ILACE, FMT_OK, 1'b1);
    fs(1'b1);
    take("R8 odd start", b + 36'(STR));
    adv();
    take("R8 odd line1", b + 36'(3 * STR));
    adv();
    check("R8 odd field end", {35'd0, req_valid}, 36'd0);
    fs(1'b0);
    take("R8 even start", b);
    adv();
    take("R8 even line1", b + 36'(2 * STR));
  endtask

  task automatic t_gate();
    setup(BASE_A, 2, 2, 2, 2, STR, MODE_RUN, 32'h0000_0800, 1'b1);
    fs(1'b0);
    check("R9 bad format", {35'd0, req_valid}, 36'd0);
    setup(BASE_A, 2, 2, 2, 2, STR, 32'h0000_0003, FMT_OK, 1'b1);
    fs(1'b0);
    check("R9 layer off", {35'd0, req_valid}, 36'd0);
    setup(BASE_A, 2, 2, 2, 2, STR, 32'h0000_0101, FMT_OK, 1'b1);
    fs(1'b0);
    check("R9 not started", {35'd0, req_valid}, 36'd0);
    setup(BASE_A, 2, 2, 2, 2, STR, MODE_RUN, FMT_OK, 1'b1);
    fs(1'b0);
    check("R9 all set", {35'd0, req_valid}, 36'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow();
    t_frame();
    t_noreload();
    t_commit_collide();
    t_stall();
    t_fs_vs_adv();
    t_ilace();
    t_gate();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule